// File: doc/BRIEF.md
# Serial memory page write collector and program-cycle timer

This block sits behind the command decoder of a serial memory slave. Once a write command and its start address have been decoded, it gathers the data bytes that follow into a page latch whose width is a power of two. The pointer inside the latch starts at the low bits of the start address and wraps inside the page, so surplus bytes replace earlier ones. When chip select rises exactly on a byte boundary with at least one byte loaded, the block starts a timed program cycle. In that cycle it replays only the loaded byte positions onto a one-byte-per-clock array write port. It then holds a busy flag for the programmed number of clocks.

A chip-select rise at any other bit position throws the collected bytes away. A write command is not accepted when the write enable latch is clear, and requests made during a program cycle are not accepted either. At the end of the cycle the block drops busy and pulses `done` for one clock. The surrounding logic uses that pulse to clear its write enable latch. Every array write stays inside the addressed page.

Top module: `pwb_ctrl`

## Requirements
- R1: During and right after reset, `busy`, `done` and `mem_we` are all low.
- R2: With n ≤ 2^PAGE_W bytes loaded after a command with start address A, byte i is written to the address whose upper bits are those of A and whose low PAGE_W bits are (A + i) mod 2^PAGE_W.
- R3: When more than 2^PAGE_W bytes are loaded, the pointer wraps inside the page, and each position holds the last byte that was sent to it.
- R4: Array writes touch only loaded positions of the addressed page, and all writes of one cycle share one page. Other locations keep their contents.
- R5: A program cycle starts only when `cs_rise` is sampled with `byte_aligned` high and at least one byte loaded. Any other `cs_rise` discards the page: no array write happens and `busy` stays low.
- R6: `busy` rises on the clock edge that samples the committing `cs_rise` and stays high for exactly CYCLE_CLKS cycles.
- R7: `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R8: A `cmd_start` sampled while `wel` is low is ignored. Bytes and `cs_rise` that follow it cause no write and no busy period.
- R9: While `busy` is high, `cmd_start`, byte strobes and `cs_rise` are ignored. No second cycle follows, and the memory receives only the first page.
- R10: `mem_we` is high only while `busy` is high. Each loaded position is written exactly once per cycle, in rising position order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel | input | 1 | Write enable latch state |
| cmd_start | input | 1 | Pulse: write command and address decoded |
| cmd_addr | input | ADDR_W | Start address of the write |
| byte_stb | input | 1 | Pulse: one complete data byte received |
| byte_dat | input | DATA_W | The received data byte |
| byte_aligned | input | 1 | Serial bit counter sits on a byte boundary |
| cs_rise | input | 1 | Pulse: chip select went high |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-clock pulse at the end of a program cycle |

## Verification
The bench builds the block with ADDR_W=8, PAGE_W=4 and CYCLE_CLKS=24, which gives sixteen pages of sixteen bytes and a cycle short enough to run many times. With that size the bench sweeps every start offset against byte counts of one, three, a full page and two lengths that wrap. After each cycle it compares the whole 256-byte array with an arithmetic model, so stray writes outside the page are caught as well. Directed runs cover a clear enable latch, a misaligned or empty chip-select rise, and traffic during a busy cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_LOAD = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pwb_latch.sv
// Page latch: byte slots, loaded mask and wrapping fill pointer.
module pwb_latch #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic [PAGE_W-1:0]              ptr_init,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [PAGE_W-1:0]              rd_idx,
    output logic [DATA_W-1:0]              rd_data,
    output logic [(1<<PAGE_W)-1:0]         mask
);
    localparam int SLOTS = 1 << PAGE_W;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] slot;
        logic [SLOTS-1:0]             mask;
        logic [PAGE_W-1:0]            ptr;
    } lat_t;

    lat_t lat_d, lat_q;
    logic [SLOTS-1:0] hit;

    // one-hot decode of the fill pointer, one select per slot
    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit[g] = wr_en && (lat_q.ptr == PAGE_W'(g));
    end

    always_comb begin
        lat_d = lat_q;
        if (clr) begin
            lat_d.mask = '0;
            lat_d.ptr  = ptr_init;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (hit[i]) begin
                    lat_d.slot[i] = wr_data;
                    lat_d.mask[i] = 1'b1;
                end
            end
            if (wr_en) begin
                lat_d.ptr = lat_q.ptr + PAGE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign rd_data = lat_q.slot[rd_idx];
    assign mask    = lat_q.mask;
endmodule

// File: rtl/pwb_timer.sv
// Program-cycle timer: runs CYCLE_CLKS clocks after a start pulse.
module pwb_timer #(
    parameter int CYCLE_CLKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic last
);
    localparam int CW = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(CYCLE_CLKS - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == LAST_CNT) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign running = tmr_q.run;
    assign last    = tmr_q.run && (tmr_q.cnt == LAST_CNT);
endmodule

// File: rtl/pwb_ctrl.sv
// Page write collector and program-cycle controller (top).
// CYCLE_CLKS must be at least 2**PAGE_W so the write-back scan fits.
module pwb_ctrl #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_W     = 4,
    parameter int DATA_W     = 8,
    parameter int CYCLE_CLKS = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_dat,
    input  logic              byte_aligned,
    input  logic              cs_rise,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done
);
    import pwb_pkg::*;

    localparam int SLOTS = 1 << PAGE_W;
    localparam int BW    = ADDR_W - PAGE_W;
    localparam int SW    = PAGE_W + 1;

    typedef struct packed {
        pw_state_e   st;
        logic [BW-1:0] base;
        logic [SW-1:0] scan;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              lat_clr;
    logic              lat_wr;
    logic [SLOTS-1:0]  lat_mask;
    logic [DATA_W-1:0] lat_rd;
    logic              tmr_start;
    logic              tmr_run;
    logic              tmr_last;

    pwb_latch #(
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (lat_clr),
        .ptr_init (cmd_addr[PAGE_W-1:0]),
        .wr_en    (lat_wr),
        .wr_data  (byte_dat),
        .rd_idx   (ctl_q.scan[PAGE_W-1:0]),
        .rd_data  (lat_rd),
        .mask     (lat_mask)
    );

    pwb_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .running (tmr_run),
        .last    (tmr_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        lat_clr    = 1'b0;
        lat_wr     = 1'b0;
        tmr_start  = 1'b0;
        unique case (ctl_q.st)
            PW_IDLE: begin
                if (cmd_start && wel) begin
                    ctl_d.st   = PW_LOAD;
                    ctl_d.base = cmd_addr[ADDR_W-1:PAGE_W];
                    lat_clr    = 1'b1;
                end
            end
            PW_LOAD: begin
                // chip select closes the command; a strobe in the same clock is dropped
                if (cs_rise) begin
                    if (byte_aligned && (|lat_mask)) begin
                        ctl_d.st   = PW_PROG;
                        ctl_d.scan = '0;
                        tmr_start  = 1'b1;
                    end else begin
                        ctl_d.st = PW_IDLE;
                    end
                end else if (byte_stb) begin
                    lat_wr = 1'b1;
                end
            end
            PW_PROG: begin
                if (!ctl_q.scan[PAGE_W]) begin
                    ctl_d.scan = ctl_q.scan + SW'(1);
                end
                if (tmr_last) begin
                    ctl_d.st   = PW_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: begin
                ctl_d.st = PW_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: PW_IDLE, base: '0, scan: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st == PW_PROG) && tmr_run;
    assign done      = ctl_q.done;
    assign mem_we    = busy && !ctl_q.scan[PAGE_W] && lat_mask[ctl_q.scan[PAGE_W-1:0]];
    assign mem_addr  = {ctl_q.base, ctl_q.scan[PAGE_W-1:0]};
    assign mem_wdata = lat_rd;
endmodule

// File: rtl/pwb_chk.sv
// Property checker attached to pwb_ctrl.
module pwb_chk #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cs_rise,
    input logic              byte_aligned
);
    assert_we_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_fall_gives_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_busy_ends_by_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_commit_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_rise) && $past(byte_aligned)));

    assert_same_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(busy) && busy && $past(mem_we)) |->
            (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

    assert_rising_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(busy) && busy) |->
            (mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0])));
endmodule

bind pwb_ctrl pwb_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_pwb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .cs_rise      (cs_rise),
    .byte_aligned (byte_aligned)
);

// File: tb/tb_pwb_ctrl.sv
`timescale 1ns/1ps
module tb_pwb_ctrl;
    localparam int AW  = 8;
    localparam int PW  = 4;
    localparam int DW  = 8;
    localparam int CYC = 24;
    localparam int NPG = 1 << PW;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wel = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_stb = 1'b0;
    logic [DW-1:0] byte_dat = '0;
    logic          byte_aligned = 1'b1;
    logic          cs_rise = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          busy;
    logic          done;

    int total = 0;
    int bad   = 0;
    int we_cnt = 0;
    int we_outside = 0;
    logic [DW-1:0] bmem [MEMN];
    logic [DW-1:0] emem [MEMN];

    always #2 clk = ~clk;

    pwb_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .CYCLE_CLKS(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .wel(wel), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_stb(byte_stb), .byte_dat(byte_dat), .byte_aligned(byte_aligned),
        .cs_rise(cs_rise), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done));

    // array model fed only by the write port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMN; i++) bmem[i] <= '0;
        end else if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
        end
        if (rst_n && mem_we) begin
            we_cnt <= we_cnt + 1;
            if (!busy) we_outside <= we_outside + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue_cmd(input logic [AW-1:0] a);
        @(negedge clk); cmd_start = 1'b1; cmd_addr = a;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [DW-1:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_dat = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic raise_cs(input logic aligned);
        @(negedge clk); cs_rise = 1'b1; byte_aligned = aligned;
        @(negedge clk); cs_rise = 1'b0; byte_aligned = 1'b1;
    endtask

    // called just after raise_cs returns; returns busy length and done behaviour
    task automatic measure(output int len, output bit done_ok);
        len = busy ? 1 : 0;
        done_ok = 1'b0;
        if (busy) begin
            for (int k = 0; k < 200; k++) begin
                @(posedge clk); #1;
                if (busy) len++;
                else break;
            end
            done_ok = done;
            @(posedge clk); #1;
            if (done) done_ok = 1'b0;
        end
    endtask

    task automatic idle_watch(input int ncyc, output bit saw_busy);
        saw_busy = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            @(posedge clk); #1;
            if (busy || done) saw_busy = 1'b1;
        end
    endtask

    function automatic int mem_diff(output int where);
        int cnt = 0;
        where = -1;
        for (int i = 0; i < MEMN; i++) begin
            if (bmem[i] !== emem[i]) begin
                if (where < 0) where = i;
                cnt++;
            end
        end
        return cnt;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len, where, nd, w0;
        bit dok, saw;
        logic [DW-1:0] pat;
        int lens [5] = '{1, 3, 16, 17, 21};
        for (int i = 0; i < MEMN; i++) emem[i] = '0;

        repeat (3) @(posedge clk); #1;
        check(busy == 0 && done == 0 && mem_we == 0, "R1", "outputs in reset",
              {busy, done, mem_we}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(busy == 0 && done == 0 && mem_we == 0, "R1", "outputs after reset",
              {busy, done, mem_we}, 0);

        // R8: command with the enable latch clear
        wel = 1'b0;
        w0 = we_cnt;
        issue_cmd(8'h35);
        send_byte(8'hAA); send_byte(8'h55); send_byte(8'h12);
        raise_cs(1'b1);
        idle_watch(CYC + 4, saw);
        check(!saw, "R8", "busy after ignored command", saw, 0);
        nd = mem_diff(where);
        check(nd == 0 && we_cnt == w0, "R8", "writes after ignored command", we_cnt - w0, 0);

        wel = 1'b1;
        // R5: misaligned chip-select rise
        w0 = we_cnt;
        issue_cmd(8'h42);
        send_byte(8'h77); send_byte(8'h88);
        raise_cs(1'b0);
        idle_watch(CYC + 4, saw);
        check(!saw && we_cnt == w0, "R5", "misaligned rise started a cycle", we_cnt - w0, 0);
        // R5: rise with no bytes loaded
        issue_cmd(8'h60);
        raise_cs(1'b1);
        idle_watch(CYC + 4, saw);
        check(!saw && we_cnt == w0, "R5", "empty rise started a cycle", we_cnt - w0, 0);
        nd = mem_diff(where);
        check(nd == 0, "R5", "memory after discarded writes", nd, 0);

        // sweep: every start offset against several lengths
        for (int o = 0; o < NPG; o++) begin
            for (int li = 0; li < 5; li++) begin
                int n, pg;
                logic [AW-1:0] a;
                n  = lens[li];
                pg = (o + n) % NPG;
                a  = AW'(pg * NPG + o);
                w0 = we_cnt;
                issue_cmd(a);
                for (int i = 0; i < n; i++) begin
                    pat = DW'(pg * 37 + o * 11 + i * 5 + n);
                    send_byte(pat);
                    emem[pg * NPG + ((o + i) % NPG)] = pat;
                end
                raise_cs(1'b1);
                measure(len, dok);
                check(len == CYC, "R6", "busy length", len, CYC);
                check(dok, "R7", "single done pulse", dok, 1);
                nd = mem_diff(where);
                if (n > NPG)
                    check(nd == 0, "R3", "wrapped page contents", nd, 0);
                else
                    check(nd == 0, "R2", "page contents", nd, 0);
                if (nd != 0 && (where / NPG) != pg)
                    check(1'b0, "R4", "write outside addressed page", where, -1);
                check(we_cnt - w0 == ((n > NPG) ? NPG : n), "R4",
                      "array write count", we_cnt - w0, (n > NPG) ? NPG : n);
            end
        end

        // R9: traffic during a busy cycle
        w0 = we_cnt;
        issue_cmd(8'h93);
        send_byte(8'hC1); send_byte(8'hC2);
        emem[8'h93] = 8'hC1; emem[8'h94] = 8'hC2;
        raise_cs(1'b1);
        issue_cmd(8'hD0);
        send_byte(8'hEE); send_byte(8'hEF);
        raise_cs(1'b1);
        for (int k = 0; k < 3 * CYC; k++) begin
            @(posedge clk); #1;
            if (done) break;
        end
        idle_watch(CYC + 4, saw);
        check(!saw, "R9", "second cycle after busy traffic", saw, 0);
        nd = mem_diff(where);
        check(nd == 0 && we_cnt - w0 == 2, "R9", "memory after busy traffic", we_cnt - w0, 2);

        check(we_outside == 0, "R10", "writes outside busy", we_outside, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule